// File: doc/BRIEF.md
# Single-Error-Correcting Word Store with Partial-Write Bypass

This block holds a small array of double-width words, each one built from two interface beats. Every write that fills all byte lanes of a word also stores check bits from an extended Hamming code: single-error-correcting and double-error-detecting, with one overall parity bit. On each read the stored word and its check bits are decoded. A single flipped bit, whether in the data or in the check field, is repaired before the word is returned. A double flip is reported as uncorrectable, and the raw word is returned unchanged.

A write that covers only some byte lanes does not perform a read-modify-write. It updates only the enabled lanes and clears a per-word protection bit. While that bit is clear, reads return the stored bits exactly as they are and raise no error flag. A later write that covers every lane rewrites the check bits and restores protection. A fault-injection port XORs a mask into one stored word, covering both its data and its check bits, so that the correction paths can be exercised.

Top module: `ecc_bypass_mem`

## Requirements
- R1: A write with every bit of `wr_be_ni` low is a full write. It stores the data and freshly encoded check bits and marks the word protected. A later read of that word returns the written data with `corr_o` and `uncorr_o` low.
- R2: A read sampled at a clock edge returns its result after the next edge. `rd_valid_o` is high for exactly one cycle per read and low otherwise.
- R3: For a protected word, a read corrects any single stored bit flip and returns the original data with `corr_o` high for that one result. This covers a data bit, a Hamming check bit, or the overall parity bit.
- R4: For a protected word holding two flipped bits, a read raises `uncorr_o`, keeps `corr_o` low and returns the stored data without modification.
- R5: `wr_be_ni` is active low, and bit k enables byte lane k, which is data bits [8k+7:8k]. A partial write (some but not all bits low) changes only the enabled lanes and leaves the other lanes unchanged.
- R6: A partial write clears the word's protection. Reads of an unprotected word return the raw stored bits, including any injected flips, with both error flags low.
- R7: A full write to an unprotected word restores protection, so single flips in that word are corrected again.
- R8: A write with every bit of `wr_be_ni` high is ignored. It changes neither the data nor the protection state of the word.
- R9: When `inj_en_i` is high, `inj_mask_i` is XORed into the word at `inj_addr_i`. Mask bits [31:0] hit the data, bits [37:32] hit the six Hamming check bits, and bit 38 hits the overall parity bit (default 32-bit word). On a same-cycle write to the same word, the mask applies on top of the newly written value.
- R10: Reset clears every protection bit and drives all outputs low. Reads of words not written since reset raise no error flag.
- R11: `corr_o` and `uncorr_o` are never high together, and neither is high without `rd_valid_o`.
- R12: A read and a write to the same word in the same cycle return the word's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_be_ni | input | LANES | Active-low byte-lane enables |
| wr_data_i | input | DATA_W | Write data (two beats) |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read word address |
| inj_en_i | input | 1 | Fault-injection strobe |
| inj_addr_i | input | ADDR_W | Word to corrupt |
| inj_mask_i | input | CODE_W | XOR mask over data and check bits |
| rd_valid_o | output | 1 | Read result valid, one cycle |
| rd_data_o | output | DATA_W | Corrected or raw read data |
| corr_o | output | 1 | Single error repaired in this result |
| uncorr_o | output | 1 | Uncorrectable error in this result |

## Verification
On every cycle, the assertions check the read latency and the one-cycle valid pulse. They also check that the two error flags are exclusive and only appear with a valid result. They track every full write that is read back on the following cycle and require its data to come back clean. The bench scenarios cover the behaviour that depends on stored history. This includes repair of flips at each kind of bit position, detection of double flips, lane merging on partial writes, loss and recovery of protection, ignored empty writes, injection on the same cycle as a write, and read-before-write ordering.

// File: rtl/ecc_bypass_pkg.sv
package ecc_bypass_pkg;

  typedef enum logic [1:0] {
    DEC_CLEAN = 2'd0,
    DEC_FIXED = 2'd1,
    DEC_FATAL = 2'd2
  } dec_kind_e;

  function automatic bit is_pow2(input int p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // Number of Hamming check bits (excluding overall parity) for dw data bits.
  function automatic int ham_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Code position (1-based) of data bit j: j-th non-power-of-two position.
  function automatic int data_pos(input int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < j + 64; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == j && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_bypass_enc.sv
module ecc_bypass_enc #(
  parameter int DATA_W = 32,
  localparam int HAM_W = ecc_bypass_pkg::ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [HAM_W-1:0] ham;

  for (genvar i = 0; i < HAM_W; i++) begin : g_chk
    logic [DATA_W-1:0] sel;
    for (genvar j = 0; j < DATA_W; j++) begin : g_sel
      localparam int POS = ecc_bypass_pkg::data_pos(j);
      if (((POS >> i) & 1) == 1) begin : g_on
        assign sel[j] = data_i[j];
      end else begin : g_off
        assign sel[j] = 1'b0;
      end
    end
    assign ham[i] = ^sel;
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/ecc_bypass_dec.sv
module ecc_bypass_dec #(
  parameter int DATA_W = 32,
  localparam int HAM_W = ecc_bypass_pkg::ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0]             data_i,
  input  logic [CHK_W-1:0]              chk_i,
  output logic [DATA_W-1:0]             data_o,
  output ecc_bypass_pkg::dec_kind_e     kind_o
);
  import ecc_bypass_pkg::*;

  logic [CHK_W-1:0]  recomp;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic [DATA_W-1:0] flip;
  logic              syn_pow2;

  ecc_bypass_enc #(.DATA_W(DATA_W)) i_enc (
    .data_i (data_i),
    .chk_o  (recomp)
  );

  assign syn = recomp[HAM_W-1:0] ^ chk_i[HAM_W-1:0];
  assign odd = (^data_i) ^ (^chk_i);
  assign syn_pow2 = (syn != '0) && ((syn & (syn - HAM_W'(1))) == '0);

  for (genvar j = 0; j < DATA_W; j++) begin : g_flip
    localparam int POS = data_pos(j);
    assign flip[j] = (syn == HAM_W'(POS));
  end

  always_comb begin
    data_o = data_i;
    kind_o = DEC_CLEAN;
    if (odd) begin
      // odd overall parity: one flip, unless the position is off the code
      if (syn == '0 || syn_pow2) begin
        kind_o = DEC_FIXED;
      end else if (|flip) begin
        kind_o = DEC_FIXED;
        data_o = data_i ^ flip;
      end else begin
        kind_o = DEC_FATAL;
      end
    end else if (syn != '0) begin
      kind_o = DEC_FATAL;
    end
  end

endmodule

// File: rtl/ecc_bypass_store.sv
module ecc_bypass_store #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 7,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = DATA_W / 8,
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_full_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_lane_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CHK_W-1:0]  wr_chk_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [CODE_W-1:0] inj_mask_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_fire_o,
  output logic              rd_prot_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CHK_W-1:0]  rd_chk_o
);

  logic [DEPTH-1:0][DATA_W-1:0] data_all;
  logic [DEPTH-1:0][CHK_W-1:0]  chk_all;
  logic [DEPTH-1:0]             prot_all;

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    logic              hit_w;
    logic              hit_i;
    logic [DATA_W-1:0] data_q, data_d;
    logic [CHK_W-1:0]  chk_q, chk_d;
    logic              prot_q;

    assign hit_w = wr_en_i && (wr_addr_i == ADDR_W'(a));
    assign hit_i = inj_en_i && (inj_addr_i == ADDR_W'(a));

    always_comb begin
      data_d = data_q;
      chk_d  = chk_q;
      if (hit_w) begin
        for (int l = 0; l < LANES; l++) begin
          if (wr_lane_i[l]) data_d[l*8 +: 8] = wr_data_i[l*8 +: 8];
        end
        if (wr_full_i) chk_d = wr_chk_i;
      end
      // injection lands on top of a same-cycle write
      if (hit_i) begin
        data_d = data_d ^ inj_mask_i[DATA_W-1:0];
        chk_d  = chk_d ^ inj_mask_i[CODE_W-1:DATA_W];
      end
    end

    always_ff @(posedge clk_i) begin
      data_q <= data_d;
      chk_q  <= chk_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    prot_q <= 1'b0;
      else if (hit_w) prot_q <= wr_full_i;
    end

    assign data_all[a] = data_q;
    assign chk_all[a]  = chk_q;
    assign prot_all[a] = prot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_fire_o <= 1'b0;
      rd_prot_o <= 1'b0;
      rd_data_o <= '0;
      rd_chk_o  <= '0;
    end else begin
      rd_fire_o <= rd_en_i;
      if (rd_en_i) begin
        rd_prot_o <= prot_all[rd_addr_i];
        rd_data_o <= data_all[rd_addr_i];
        rd_chk_o  <= chk_all[rd_addr_i];
      end
    end
  end

endmodule

// File: rtl/ecc_bypass_mem.sv
module ecc_bypass_mem #(
  parameter int BEAT_W = 16,
  parameter int DEPTH  = 16,
  localparam int DATA_W = 2 * BEAT_W,
  localparam int LANES  = DATA_W / 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int HAM_W  = ecc_bypass_pkg::ham_bits(DATA_W),
  localparam int CHK_W  = HAM_W + 1,
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_be_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [CODE_W-1:0] inj_mask_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  import ecc_bypass_pkg::*;

  logic [LANES-1:0]  lane_on;
  logic              wr_any, wr_full;
  logic [CHK_W-1:0]  enc_chk;
  logic              st_fire, st_prot;
  logic [DATA_W-1:0] st_data, dec_data;
  logic [CHK_W-1:0]  st_chk;
  dec_kind_e         dec_kind;

  assign lane_on = ~wr_be_ni;
  assign wr_any  = wr_en_i && (|lane_on);
  assign wr_full = wr_en_i && (&lane_on);

  ecc_bypass_enc #(.DATA_W(DATA_W)) i_enc (
    .data_i (wr_data_i),
    .chk_o  (enc_chk)
  );

  ecc_bypass_store #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .DEPTH  (DEPTH)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_any),
    .wr_full_i  (wr_full),
    .wr_addr_i  (wr_addr_i),
    .wr_lane_i  (lane_on),
    .wr_data_i  (wr_data_i),
    .wr_chk_i   (enc_chk),
    .inj_en_i   (inj_en_i),
    .inj_addr_i (inj_addr_i),
    .inj_mask_i (inj_mask_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_fire_o  (st_fire),
    .rd_prot_o  (st_prot),
    .rd_data_o  (st_data),
    .rd_chk_o   (st_chk)
  );

  ecc_bypass_dec #(.DATA_W(DATA_W)) i_dec (
    .data_i (st_data),
    .chk_i  (st_chk),
    .data_o (dec_data),
    .kind_o (dec_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      corr_o     <= 1'b0;
      uncorr_o   <= 1'b0;
    end else begin
      rd_valid_o <= st_fire;
      corr_o     <= st_fire && st_prot && (dec_kind == DEC_FIXED);
      uncorr_o   <= st_fire && st_prot && (dec_kind == DEC_FATAL);
      if (st_fire) rd_data_o <= st_prot ? dec_data : st_data;
    end
  end

endmodule

// File: rtl/ecc_bypass_mem_chk.sv
module ecc_bypass_mem_chk #(
  parameter int BEAT_W = 16,
  parameter int DEPTH  = 16,
  localparam int DATA_W = 2 * BEAT_W,
  localparam int LANES  = DATA_W / 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int HAM_W  = ecc_bypass_pkg::ham_bits(DATA_W),
  localparam int CODE_W = DATA_W + HAM_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [LANES-1:0]  wr_be_ni,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              inj_en_i,
  input logic [ADDR_W-1:0] inj_addr_i,
  input logic [CODE_W-1:0] inj_mask_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              corr_o,
  input logic              uncorr_o
);

  logic [1:0]        cyc_q;
  logic              p1_q, p2_q, p3_q;
  logic [ADDR_W-1:0] a1_q;
  logic [DATA_W-1:0] d1_q, d2_q, d3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      p1_q  <= 1'b0;
      p2_q  <= 1'b0;
      p3_q  <= 1'b0;
      a1_q  <= '0;
      d1_q  <= '0;
      d2_q  <= '0;
      d3_q  <= '0;
    end else begin
      if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
      p1_q <= wr_en_i && (wr_be_ni == '0) && !(inj_en_i && inj_addr_i == wr_addr_i);
      a1_q <= wr_addr_i;
      d1_q <= wr_data_i;
      p2_q <= p1_q && rd_en_i && (rd_addr_i == a1_q);
      d2_q <= d1_q;
      p3_q <= p2_q;
      d3_q <= d2_q;
    end
  end

  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (rd_valid_o == $past(rd_en_i, 2)));

  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_o && uncorr_o));

  a_r11_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o || uncorr_o) |-> rd_valid_o);

  a_r1_full_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p3_q |-> (rd_valid_o && rd_data_o == d3_q && !corr_o && !uncorr_o));

  a_r10_reset_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd0) |-> (!rd_valid_o && !corr_o && !uncorr_o));

endmodule

bind ecc_bypass_mem ecc_bypass_mem_chk #(.BEAT_W(BEAT_W), .DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_ecc_bypass_mem.sv
module test_ecc_bypass_mem;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int CODE_W = 39;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [LANES-1:0]  wr_be_n = '1;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              inj_en = 1'b0;
  logic [ADDR_W-1:0] inj_addr = '0;
  logic [CODE_W-1:0] inj_mask = '0;
  logic              rd_valid, corr, uncorr;
  logic [DATA_W-1:0] rd_data;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_bypass_mem #(.BEAT_W(16), .DEPTH(16)) i_ecc_bypass_mem (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_be_ni   (wr_be_n),
    .wr_data_i  (wr_data),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .inj_en_i   (inj_en),
    .inj_addr_i (inj_addr),
    .inj_mask_i (inj_mask),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data),
    .corr_o     (corr),
    .uncorr_o   (uncorr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic [LANES-1:0] be_n);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be_n = be_n;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_be_n = '1;
  endtask

  task automatic do_inject(input logic [ADDR_W-1:0] a, input logic [CODE_W-1:0] m);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = a; inj_mask = m;
    @(posedge clk);
    @(negedge clk);
    inj_en = 1'b0; inj_mask = '0;
  endtask

  // read, sample result one edge after the read edge, then confirm the pulse ends
  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp_d,
                         input bit chk_d, input bit exp_c, input bit exp_u, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(rd_valid == 1'b1, "R2", "rd_valid", 64'(rd_valid), 64'd1);
    if (chk_d) check(rd_data == exp_d, req, "rd_data", 64'(rd_data), 64'(exp_d));
    check(corr == exp_c, req, "corr", 64'(corr), 64'(exp_c));
    check(uncorr == exp_u, req, "uncorr", 64'(uncorr), 64'(exp_u));
    @(posedge clk);
    @(negedge clk);
    check(!rd_valid && !corr && !uncorr, "R11", "flags after pulse",
          64'({rd_valid, corr, uncorr}), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!rd_valid && !corr && !uncorr && rd_data == '0, "R10", "reset outputs",
          64'({rd_valid, corr, uncorr, rd_data}), 64'd0);
    do_read(4'd5, '0, 1'b0, 1'b0, 1'b0, "R10");
  endtask

  task automatic t_full_write();
    do_write(4'd1, 32'hCAFE_1234, 4'b0000);
    do_read(4'd1, 32'hCAFE_1234, 1'b1, 1'b0, 1'b0, "R1");
    do_write(4'd2, 32'h0000_0000, 4'b0000);
    do_write(4'd15, 32'hFFFF_FFFF, 4'b0000);
    do_read(4'd2, 32'h0000_0000, 1'b1, 1'b0, 1'b0, "R1");
    do_read(4'd15, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_single_flip();
    do_write(4'd7, 32'h5A5A_0F0F, 4'b0000);
    do_inject(4'd7, CODE_W'(1) << 7);
    do_read(4'd7, 32'h5A5A_0F0F, 1'b1, 1'b1, 1'b0, "R3");
    do_write(4'd7, 32'h1357_9BDF, 4'b0000);
    do_inject(4'd7, CODE_W'(1) << 31);
    do_read(4'd7, 32'h1357_9BDF, 1'b1, 1'b1, 1'b0, "R3");
    do_write(4'd7, 32'h8000_0001, 4'b0000);
    do_inject(4'd7, CODE_W'(1) << 34);
    do_read(4'd7, 32'h8000_0001, 1'b1, 1'b1, 1'b0, "R3");
    do_write(4'd7, 32'h2468_ACE0, 4'b0000);
    do_inject(4'd7, CODE_W'(1) << 38);
    do_read(4'd7, 32'h2468_ACE0, 1'b1, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_double_flip();
    logic [CODE_W-1:0] m;
    m = (CODE_W'(1) << 3) | (CODE_W'(1) << 20);
    do_write(4'd4, 32'hDEAD_BEEF, 4'b0000);
    do_inject(4'd4, m);
    do_read(4'd4, 32'hDEAD_BEEF ^ m[DATA_W-1:0], 1'b1, 1'b0, 1'b1, "R4");
    do_write(4'd4, 32'h0F0F_F0F0, 4'b0000);
    do_inject(4'd4, (CODE_W'(1) << 0) | (CODE_W'(1) << 33));
    do_read(4'd4, 32'h0F0F_F0F1, 1'b1, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_partial();
    do_write(4'd3, 32'h1122_3344, 4'b0000);
    do_write(4'd3, 32'hAABB_CCDD, 4'b1010);   // lanes 0 and 2 enabled
    do_read(4'd3, 32'h11BB_33DD, 1'b1, 1'b0, 1'b0, "R5");
    do_inject(4'd3, CODE_W'(1) << 12);
    do_read(4'd3, 32'h11BB_23DD, 1'b1, 1'b0, 1'b0, "R6");
    do_inject(4'd3, (CODE_W'(1) << 0) | (CODE_W'(1) << 36));
    do_read(4'd3, 32'h11BB_23DC, 1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_restore();
    do_write(4'd3, 32'h7777_8888, 4'b0000);
    do_inject(4'd3, CODE_W'(1) << 25);
    do_read(4'd3, 32'h7777_8888, 1'b1, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_empty_write();
    do_write(4'd9, 32'h3C3C_C3C3, 4'b0000);
    do_write(4'd9, 32'h0000_0000, 4'b1111);
    do_read(4'd9, 32'h3C3C_C3C3, 1'b1, 1'b0, 1'b0, "R8");
    do_inject(4'd9, CODE_W'(1) << 16);
    do_read(4'd9, 32'h3C3C_C3C3, 1'b1, 1'b1, 1'b0, "R8");
  endtask

  task automatic t_inject_on_write();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd11; wr_data = 32'h9999_AAAA; wr_be_n = 4'b0000;
    inj_en = 1'b1; inj_addr = 4'd11; inj_mask = CODE_W'(1) << 2;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_be_n = '1; inj_en = 1'b0; inj_mask = '0;
    do_read(4'd11, 32'h9999_AAAA, 1'b1, 1'b1, 1'b0, "R9");
  endtask

  task automatic t_read_write_same();
    do_write(4'd6, 32'hABCD_0001, 4'b0000);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd6; wr_data = 32'hABCD_0002; wr_be_n = 4'b0000;
    rd_en = 1'b1; rd_addr = 4'd6;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_be_n = '1; rd_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(rd_valid && rd_data == 32'hABCD_0001, "R12", "old data on collision",
          64'(rd_data), 64'h0000_0000_ABCD_0001);
    do_read(4'd6, 32'hABCD_0002, 1'b1, 1'b0, 1'b0, "R12");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_write();
    t_single_flip();
    t_double_flip();
    t_partial();
    t_restore();
    t_empty_write();
    t_inject_on_write();
    t_read_write_same();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

endmodule